// File: doc/BRIEF.md
# Energy and multiplicity trigger

This block makes the physics trigger decision for one detector module. Every clock it takes one discriminator hit bit and one unsigned charge sample from each photomultiplier channel. A pipelined reduction tree counts the channels that fired and sums the charge for that clock. A running window of the last `W` per-clock results then gives the fired-channel count and the total charge over the integration window. With a 25 ns clock and `W = 4`, the window is 100 ns. The physics condition is true when either window total is strictly greater than its programmable threshold.

A small two-state machine turns the physics condition into one accept per excursion above threshold. State `ST_ARMED` moves to `ST_OVER` (transition "fired") when the condition is accepted. `ST_OVER` moves back to `ST_ARMED` (transition "re-armed") once the condition has dropped. If readout is holding off, `ST_ARMED` stays put (transition "held").

The block merges the physics condition with the LED, radioactive-source and muon pulses and with an internal periodic generator. Each accept carries a type word with one bit per source and a 32-bit running accept count. The block keeps no dead-time of its own. Only the downstream inhibit blocks accepts, and accepts may occur on consecutive clocks.

Top module: `trg_energy_mult`

## Requirements
- R1: The physics condition is true when the number of set hit bits, summed over the last `W` sampled clocks, is strictly greater than `mult_thr_i`. At the threshold value itself the condition is false.
- R2: The physics condition is also true when the sum of all channel charge samples over the last `W` sampled clocks is strictly greater than `energy_thr_i`. Channel `c` charge is `charge_i[c*QW +: QW]`.
- R3: The physics condition is the OR of R1 and R2. An accept it causes sets type bit 0. `accept_o` is high exactly when `type_o` is non-zero, and `type_o` is zero otherwise.
- R4: Inputs sampled at clock edge `e` affect the physics decision registered at edge `e + log2(N/G) + 2`. That is 6 clocks (150 ns) at the default parameters.
- R5: An LED, source or muon pulse sampled at an edge without inhibit produces an accept at that edge, with type bit 1, 2 or 4 respectively. Sources present together share one accept with several bits set.
- R6: With `period_i = P` non-zero, the periodic source fires once every `P` clocks with type bit 3. Its counter starts at zero after reset, and it fires when the counter reaches `P-1` or more. With `P = 0` it never fires.
- R7: No accept is produced at an edge where `inhibit_i` is high, and sources present at that edge are dropped. A physics condition that is still true fires on the first edge at which inhibit is sampled low.
- R8: A physics condition that stays true gives one physics accept only. Another physics accept needs the condition to be false at one edge or more first.
- R9: `count_o` increases by one with each accept and is presented together with it, so the first accept after reset carries 1. Otherwise it holds its value.
- R10: During reset, `accept_o`, `type_o` and `count_o` are zero.
- R11: Accepts can occur on consecutive clocks; no hold-off follows an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (25 ns nominal) |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | N | Per-channel discriminator hit bits |
| charge_i | input | N*QW | Per-channel unsigned charge samples, channel c at bits c*QW +: QW |
| mult_thr_i | input | HW | Multiplicity threshold (window count must exceed it) |
| energy_thr_i | input | QSW | Energy threshold (window charge sum must exceed it) |
| led_i | input | 1 | LED calibration trigger pulse |
| source_i | input | 1 | Radioactive source trigger pulse |
| muon_i | input | 1 | Muon trigger pulse |
| period_i | input | PW | Periodic trigger interval in clocks, 0 disables |
| inhibit_i | input | 1 | Readout hold-off; blocks accepts while high |
| accept_o | output | 1 | One-clock accept pulse |
| type_o | output | 5 | Source bits: 0 physics, 1 LED, 2 source, 3 periodic, 4 muon |
| count_o | output | 32 | Running accept count, includes the current accept |

At the defaults, HW = 11 and QSW = 19.

## Verification
The bench builds the block with N = 32 channels in groups of G = 8, 4-bit charge, a 4-clock window and an 8-bit period. The tree therefore has two adder levels and a 4-clock decision latency. At these sizes a threshold of 15 sits at a point a few channels can cross from either side, and a single 16-hit cycle or a split 8+8 is easy to arrange. Periods of 1, 3 and 5 show the generator wrapping many times within a short run. Random hit and charge densities, auxiliary pulses and inhibit are mixed with directed boundary and sustained-condition cases and compared cycle by cycle with a model derived from the requirements.

// File: rtl/trg_pkg.sv
package trg_pkg;
    localparam int TYPE_W  = 5;
    localparam int CNT_W   = 32;
    localparam int TB_PHYS = 0;
    localparam int TB_LED  = 1;
    localparam int TB_SRC  = 2;
    localparam int TB_PER  = 3;
    localparam int TB_MUON = 4;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_OVER  = 1'b1
    } phys_st_t;
endpackage

// File: rtl/trg_sum_tree.sv
// Pipelined reduction: registered group sums, then one registered adder level
// per tree level. Latency = 1 + log2(N/G) clocks. N/G must be a power of two.
module trg_sum_tree #(
    parameter int N  = 256,
    parameter int IW = 1,
    parameter int G  = 16,
    parameter int OW = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*IW-1:0] in_i,
    output logic [OW-1:0]   sum_o
);
    localparam int NG    = N / G;
    localparam int NODES = 2 * NG - 1;

    logic [OW-1:0] grp  [NG];
    logic [OW-1:0] node [NODES];

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            grp[g] = '0;
            for (int k = 0; k < G; k++) begin
                grp[g] = grp[g] + OW'(in_i[(g*G+k)*IW +: IW]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NODES; i++) node[i] <= '0;
        end else begin
            for (int i = 0; i < NG - 1; i++) node[i] <= node[2*i+1] + node[2*i+2];
            for (int g = 0; g < NG; g++) node[NG-1+g] <= grp[g];
        end
    end

    assign sum_o = node[0];
endmodule

// File: rtl/trg_window.sv
// Running sum over the last W inputs: add the newest, drop the oldest.
module trg_window #(
    parameter int W  = 4,
    parameter int DW = 9,
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] val_i,
    output logic [SW-1:0] sum_o
);
    logic [DW-1:0] hist [W];
    logic [SW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            for (int i = 0; i < W; i++) hist[i] <= '0;
        end else begin
            acc     <= acc + SW'(val_i) - SW'(hist[W-1]);
            hist[0] <= val_i;
            for (int i = 1; i < W; i++) hist[i] <= hist[i-1];
        end
    end

    assign sum_o = acc;
endmodule

// File: rtl/trg_period.sv
// Periodic source: tick once every period_i clocks, silent when period_i is 0.
module trg_period #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] period_i,
    output logic          tick_o
);
    logic [PW-1:0] cnt;

    assign tick_o = (period_i != '0) && (cnt >= period_i - PW'(1));

    always_ff @(posedge clk) begin
        if (rst)                              cnt <= '0;
        else if (tick_o || period_i == '0)    cnt <= '0;
        else                                  cnt <= cnt + PW'(1);
    end
endmodule

// File: rtl/trg_energy_mult.sv
module trg_energy_mult
    import trg_pkg::*;
#(
    parameter int N  = 256,
    parameter int G  = 16,
    parameter int QW = 8,
    parameter int W  = 4,
    parameter int PW = 16,
    localparam int HW  = $clog2(N * W + 1),
    localparam int QSW = QW + $clog2(N * W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      hit_i,
    input  logic [N*QW-1:0]   charge_i,
    input  logic [HW-1:0]     mult_thr_i,
    input  logic [QSW-1:0]    energy_thr_i,
    input  logic              led_i,
    input  logic              source_i,
    input  logic              muon_i,
    input  logic [PW-1:0]     period_i,
    input  logic              inhibit_i,
    output logic              accept_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int HCW     = $clog2(N + 1);
    localparam int QCW     = QW + $clog2(N) + 1;
    localparam int LEVELS  = $clog2(N / G);
    localparam int LATENCY = LEVELS + 2;  // sample edge to accept edge

    logic [HCW-1:0] hit_cyc;
    logic [QCW-1:0] q_cyc;
    logic [HW-1:0]  hit_win;
    logic [QSW-1:0] q_win;
    logic           per_tick;

    trg_sum_tree #(.N(N), .IW(1), .G(G), .OW(HCW)) u_hit_tree (
        .clk(clk), .rst(rst), .in_i(hit_i), .sum_o(hit_cyc));

    trg_sum_tree #(.N(N), .IW(QW), .G(G), .OW(QCW)) u_q_tree (
        .clk(clk), .rst(rst), .in_i(charge_i), .sum_o(q_cyc));

    trg_window #(.W(W), .DW(HCW), .SW(HW)) u_hit_win (
        .clk(clk), .rst(rst), .val_i(hit_cyc), .sum_o(hit_win));

    trg_window #(.W(W), .DW(QCW), .SW(QSW)) u_q_win (
        .clk(clk), .rst(rst), .val_i(q_cyc), .sum_o(q_win));

    trg_period #(.PW(PW)) u_period (
        .clk(clk), .rst(rst), .period_i(period_i), .tick_o(per_tick));

    phys_st_t          state, state_nx;
    logic              phys_lvl;
    logic [TYPE_W-1:0] src_vec;
    logic              fire;

    assign phys_lvl = (hit_win > mult_thr_i) || (q_win > energy_thr_i);

    always_comb begin
        src_vec          = '0;
        src_vec[TB_PHYS] = phys_lvl && (state == ST_ARMED);
        src_vec[TB_LED]  = led_i;
        src_vec[TB_SRC]  = source_i;
        src_vec[TB_PER]  = per_tick;
        src_vec[TB_MUON] = muon_i;
        fire             = !inhibit_i && (src_vec != '0);
    end

    // next-state: fired / held / re-armed
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: if (phys_lvl && !inhibit_i) state_nx = ST_OVER;
            ST_OVER:  if (!phys_lvl)              state_nx = ST_ARMED;
            default:                              state_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARMED;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o <= 1'b0;
            type_o   <= '0;
            count_o  <= '0;
        end else begin
            accept_o <= fire;
            type_o   <= fire ? src_vec : '0;
            if (fire) count_o <= count_o + CNT_W'(1);
        end
    end
endmodule

// File: rtl/trg_em_chk.sv
module trg_em_chk
    import trg_pkg::*;
#(
    parameter int PW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              led_i,
    input logic              inhibit_i,
    input logic [PW-1:0]     period_i,
    input logic              accept_o,
    input logic [TYPE_W-1:0] type_o,
    input logic [CNT_W-1:0]  count_o
);
    a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
        inhibit_i |=> !accept_o);

    a_r3_type_with_accept: assert property (@(posedge clk) disable iff (rst)
        accept_o == (type_o != '0));

    a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> count_o == $past(count_o) + CNT_W'(1));

    a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
        !accept_o |-> $stable(count_o));

    a_r5_led_accepted: assert property (@(posedge clk) disable iff (rst)
        (led_i && !inhibit_i) |=> (accept_o && type_o[TB_LED]));

    a_r6_periodic_off: assert property (@(posedge clk) disable iff (rst)
        (period_i == '0) |=> !type_o[TB_PER]);
endmodule

bind trg_energy_mult trg_em_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .led_i(led_i), .inhibit_i(inhibit_i),
    .period_i(period_i), .accept_o(accept_o), .type_o(type_o), .count_o(count_o));

// File: tb/trg_energy_mult_tb.sv
module trg_energy_mult_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 32;
    localparam int G  = 8;
    localparam int QW = 4;
    localparam int W  = 4;
    localparam int PW = 8;
    localparam int HW  = $clog2(N * W + 1);
    localparam int QSW = QW + $clog2(N * W) + 1;
    localparam int D   = $clog2(N / G) + 2;
    localparam int MAXC = 8192;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    hit = '0;
    logic [N*QW-1:0] chg = '0;
    logic [HW-1:0]   mthr = '0;
    logic [QSW-1:0]  ethr = '0;
    logic            led = 1'b0, src = 1'b0, muon = 1'b0, inh = 1'b0;
    logic [PW-1:0]   pn = '0;
    logic            accept;
    logic [4:0]      typ;
    logic [31:0]     cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    trg_energy_mult #(.N(N), .G(G), .QW(QW), .W(W), .PW(PW)) u_dut (
        .clk(clk), .rst(rst), .hit_i(hit), .charge_i(chg),
        .mult_thr_i(mthr), .energy_thr_i(ethr),
        .led_i(led), .source_i(src), .muon_i(muon),
        .period_i(pn), .inhibit_i(inh),
        .accept_o(accept), .type_o(typ), .count_o(cnt));

    int checks = 0, errors = 0;
    int hh [MAXC];
    int qq [MAXC];
    int n = 0, mcnt = 0, mst = 0;
    int unsigned mcount = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", tag, what, act, exp, n);
        end
    endtask

    function automatic int count_hits(input logic [N-1:0] h);
        int s = 0;
        for (int i = 0; i < N; i++) s += int'(h[i]);
        return s;
    endfunction

    function automatic int sum_charge(input logic [N*QW-1:0] c);
        int s = 0;
        for (int i = 0; i < N; i++) s += int'(c[i*QW +: QW]);
        return s;
    endfunction

    function automatic logic [N-1:0] first_hits(input int k);
        logic [N-1:0] h = '0;
        for (int i = 0; i < N; i++) if (i < k) h[i] = 1'b1;
        return h;
    endfunction

    task automatic clear_in();
        hit = '0; chg = '0; led = 0; src = 0; muon = 0; inh = 0;
    endtask

    task automatic rand_hits(input int pct);
        for (int i = 0; i < N; i++) hit[i] = (($urandom % 100) < pct);
    endtask

    task automatic rand_charge(input int pct);
        for (int i = 0; i < N; i++)
            chg[i*QW +: QW] = (($urandom % 100) < pct) ? QW'($urandom % 16) : '0;
    endtask

    // one clock: record stimulus, advance model at the edge, compare at negedge
    task automatic cycle(input string tag);
        int wh, wq, srcv, tick;
        bit lvl, fire;
        hh[n] = count_hits(hit);
        qq[n] = sum_charge(chg);
        @(posedge clk);
        wh = 0; wq = 0;
        for (int k = n - D - W + 1; k <= n - D; k++)
            if (k >= 0) begin wh += hh[k]; wq += qq[k]; end
        lvl  = (wh > int'(mthr)) || (wq > int'(ethr));
        tick = (pn != 0 && mcnt >= int'(pn) - 1) ? 1 : 0;
        mcnt = (tick == 1 || pn == 0) ? 0 : mcnt + 1;
        srcv = (int'(muon) << 4) | (tick << 3) | (int'(src) << 2) | (int'(led) << 1)
             | ((lvl && mst == 0) ? 1 : 0);
        fire = !inh && srcv != 0;
        if (mst == 0 && lvl && !inh) mst = 1;
        else if (mst == 1 && !lvl)   mst = 0;
        if (fire) mcount++;
        n++;
        @(negedge clk);
        chk(tag, "accept", accept, fire);
        chk(tag, "type", typ, fire ? srcv : 0);
        chk("R9", "count", cnt, mcount);
    endtask

    task automatic idle(input string tag, input int k);
        clear_in();
        for (int i = 0; i < k; i++) cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "accept", accept, 0);
        chk("R10", "type", typ, 0);
        chk("R10", "count", cnt, 0);
        rst = 0;

        // R1: multiplicity boundary, charge path disabled
        mthr = 15; ethr = '1; pn = 0;
        clear_in(); hit = first_hits(15); cycle("R1"); idle("R1", 10);
        hit = first_hits(16); cycle("R1"); idle("R1", 10);
        hit = first_hits(8); cycle("R1"); hit = first_hits(8); cycle("R1"); idle("R1", 10);
        // R4: one 20-hit cycle after quiet, accept exactly D edges later
        hit = first_hits(20); cycle("R4"); idle("R4", 10);
        for (int i = 0; i < 200; i++) begin clear_in(); rand_hits(10); cycle("R1"); end
        idle("R1", 10);

        // R8: sustained condition gives one physics accept, then a second after it drops
        hit = first_hits(16);
        for (int i = 0; i < 10; i++) cycle("R8");
        idle("R8", 10);
        hit = first_hits(16); cycle("R8"); idle("R8", 10);

        // R2: energy boundary, multiplicity path disabled
        mthr = '1; ethr = 15;
        clear_in(); chg[0 +: QW] = 4'd15; cycle("R2"); idle("R2", 10);
        chg[0 +: QW] = 4'd15; cycle("R2");
        clear_in(); chg[QW +: QW] = 4'd1; cycle("R2"); idle("R2", 10);
        for (int i = 0; i < 200; i++) begin clear_in(); rand_charge(5); cycle("R2"); end
        idle("R2", 10);

        // R3: both criteria active
        mthr = 20; ethr = 40;
        for (int i = 0; i < 300; i++) begin
            clear_in(); rand_hits(15); rand_charge(10); cycle("R3");
        end
        idle("R3", 10);

        // R5: auxiliary pulses with physics quiet
        for (int i = 0; i < 200; i++) begin
            clear_in();
            led = (($urandom % 100) < 30); src = (($urandom % 100) < 30);
            muon = (($urandom % 100) < 30);
            cycle("R5");
        end
        // R11: back-to-back accepts
        clear_in(); muon = 1;
        for (int i = 0; i < 10; i++) cycle("R11");
        idle("R11", 3);

        // R6: periodic generator
        pn = 5; idle("R6", 40);
        pn = 0; idle("R6", 40);
        pn = 1; idle("R6", 20);
        pn = 3;
        for (int i = 0; i < 60; i++) begin
            clear_in(); led = (($urandom % 100) < 20); cycle("R6");
        end
        pn = 0; idle("R6", 10);

        // R7: physics held off by inhibit, fires on release
        mthr = 15; ethr = '1;
        clear_in(); inh = 1; hit = first_hits(20); cycle("R7");
        hit = '0;
        for (int i = 0; i < D + 1; i++) cycle("R7");
        inh = 0; idle("R7", 10);
        // R7: random mix with inhibit
        mthr = 12; ethr = 30; pn = 7;
        for (int i = 0; i < 400; i++) begin
            clear_in(); rand_hits(12); rand_charge(8);
            led = (($urandom % 100) < 10); src = (($urandom % 100) < 10);
            muon = (($urandom % 100) < 10); inh = (($urandom % 100) < 40);
            cycle("R7");
        end
        pn = 0; idle("R7", 10);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule